// File: doc/BRIEF.md
# Drift-Compensated Nanosecond Time Counter

This block keeps a 64-bit nanosecond time-of-day value for a hardware clock used in precision time protocol work. Every clock cycle the value advances by a fixed nominal step, 16 ns for a 62.5 MHz reference. A periodic corrector trims the rate. After a programmed interval, counted in 16 ns quanta, it adds or removes between 0 and 7 ns on one increment, then starts a new interval.

Software reaches the block through a small word-wide register port. Software can pause the counter, write either 32-bit half of the time value while it is paused, and resume it. To reprogram the corrector, software raises a hold bit, writes the drift word, and lowers the hold bit. Lowering the hold bit starts the corrector on a fresh interval. Reading the low half of the time value captures the high half, so a later read of the high half matches it. The time value is also available on a port for local consumers.

Top module: `ns_time_counter`

## Requirements
- R1: After synchronous reset, the time value is 0 and the counter is running. The status register (address 0) reads 0. The drift word (address 3) reads 0. The hold bit (address 4) reads 0.
- R2: While running with no correction due, the time value grows by STEP_NS on each clock cycle and wraps modulo 2^64.
- R3: Writing 2 to address 0 pauses the counter and writing 4 resumes it. Any other value has no effect. While paused, the time value does not change, and bit 0 of address 0 reads 1.
- R4: While paused, a write to address 1 replaces time bits 31:0 and a write to address 2 replaces bits 63:32. Both writes are ignored while the counter runs.
- R5: The drift word at address 3 has three fields: bit 31 is the direction (1 add, 0 subtract), bits 30:28 are the magnitude in ns, and bits 27:0 are the period in 16 ns quanta. A write to address 3 takes effect only while the hold bit is set. The register reads back the stored word.
- R6: Bit 0 of a write to address 4 sets or clears the hold bit, and address 4 reads the hold bit back in bit 0.
- R7: With hold clear and period P, every P-th running cycle carries a step of STEP_NS plus or minus the magnitude. A period of 0 or 1 corrects on every cycle. A period of 0x0FFFFFFF is the longest interval and the interval counter does not wrap.
- R8: A magnitude of 0, including an all-zero drift word, gives no correction.
- R9: Two conditions freeze the interval countdown: the counter being paused, and the hold bit being set. While the hold bit is set, the countdown is reloaded from the period, so clearing the hold bit starts a full new interval.
- R10: A read of address 5 returns time bits 31:0 and captures bits 63:32. A read of address 6 returns the captured high half. Read data appears on the cycle after the read strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered one cycle after rd_en |
| time_ns | output | 64 | Current time value in ns |

## Verification
The interval countdown and the pause flag are internal state, and neither can be read directly. A fault in either one shows up only as extra or missing nanoseconds in the time value, so it appears after a full correction interval of running cycles. Every time check therefore pauses the counter and reads the value back. Each expected value is the loaded start value, plus STEP_NS times the number of running cycles, plus or minus the magnitude times the number of completed intervals. A countdown that was not restarted when the hold bit cleared shows up as a correction arriving too early in the very next interval. A broken capture of the high half shows up on the first split read.

// File: rtl/nsc_pkg.sv
package nsc_pkg;

    localparam int TIME_W   = 64;
    localparam int REG_W    = 32;
    localparam int ADDR_W   = 3;
    localparam int PERIOD_W = 28;
    localparam int MAG_W    = 3;

    typedef enum logic [ADDR_W-1:0] {
        RA_CTRL       = 3'd0,
        RA_LOAD_LO    = 3'd1,
        RA_LOAD_HI    = 3'd2,
        RA_DRIFT_CFG  = 3'd3,
        RA_DRIFT_HOLD = 3'd4,
        RA_TIME_LO    = 3'd5,
        RA_TIME_HI    = 3'd6
    } reg_addr_e;

    localparam logic [REG_W-1:0] CMD_PAUSE  = 32'd2;
    localparam logic [REG_W-1:0] CMD_RESUME = 32'd4;

    // field order is fixed by the software-visible word layout
    typedef struct packed {
        logic                add;
        logic [MAG_W-1:0]    mag;
        logic [PERIOD_W-1:0] period;
    } drift_cfg_t;

    function automatic logic [REG_W-1:0] flag_word(input logic b);
        return {{(REG_W-1){1'b0}}, b};
    endfunction

endpackage

// File: rtl/nsc_regif.sv
module nsc_regif
    import nsc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    input  logic [TIME_W-1:0] time_ns,
    output logic              paused,
    output logic              drift_hold,
    output drift_cfg_t        cfg,
    output logic              load_lo_we,
    output logic              load_hi_we,
    output logic [REG_W-1:0]  snap_hi,
    output logic [REG_W-1:0]  rdata
);

    reg_addr_e sel;
    assign sel = reg_addr_e'(addr);

    assign load_lo_we = wr_en && (sel == RA_LOAD_LO) && paused;
    assign load_hi_we = wr_en && (sel == RA_LOAD_HI) && paused;

    always_ff @(posedge clk) begin
        if (rst) begin
            paused     <= 1'b0;
            drift_hold <= 1'b0;
            cfg        <= '0;
        end else if (wr_en) begin
            case (sel)
                RA_CTRL: begin
                    if (wdata == CMD_PAUSE)       paused <= 1'b1;
                    else if (wdata == CMD_RESUME) paused <= 1'b0;
                end
                RA_DRIFT_CFG:  if (drift_hold) cfg <= drift_cfg_t'(wdata);
                RA_DRIFT_HOLD: drift_hold <= wdata[0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata   <= '0;
            snap_hi <= '0;
        end else if (rd_en) begin
            case (sel)
                RA_CTRL:       rdata <= flag_word(paused);
                RA_DRIFT_CFG:  rdata <= cfg;
                RA_DRIFT_HOLD: rdata <= flag_word(drift_hold);
                RA_TIME_LO: begin
                    rdata   <= time_ns[REG_W-1:0];
                    snap_hi <= time_ns[TIME_W-1:REG_W];
                end
                RA_TIME_HI:    rdata <= snap_hi;
                default:       rdata <= '0;
            endcase
        end
    end

endmodule

// File: rtl/nsc_drift.sv
module nsc_drift
    import nsc_pkg::*;
#(
    parameter int STEP_NS    = 16,
    parameter int QUANTUM_NS = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             hold,
    input  drift_cfg_t       cfg,
    output logic             corr_fire,
    output logic             corr_add,
    output logic [MAG_W-1:0] corr_mag
);

    localparam int                  QPC   = STEP_NS / QUANTUM_NS;
    localparam logic [PERIOD_W-1:0] QPC_V = PERIOD_W'(QPC);

    logic [PERIOD_W-1:0] left;
    logic                due;

    // reload instead of decrementing past the last quantum: no wrap at any period
    assign due       = (left <= QPC_V);
    assign corr_fire = run && !hold && due && (cfg.mag != '0);
    assign corr_add  = cfg.add;
    assign corr_mag  = cfg.mag;

    always_ff @(posedge clk) begin
        if (rst)       left <= '0;
        else if (hold) left <= cfg.period;
        else if (run)  left <= due ? cfg.period : left - QPC_V;
    end

endmodule

// File: rtl/nsc_count.sv
module nsc_count
    import nsc_pkg::*;
#(
    parameter int STEP_NS = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              load_lo_we,
    input  logic              load_hi_we,
    input  logic [REG_W-1:0]  wdata,
    input  logic              corr_fire,
    input  logic              corr_add,
    input  logic [MAG_W-1:0]  corr_mag,
    output logic [TIME_W-1:0] time_ns
);

    localparam int STEP_W = $clog2(STEP_NS + 8) + 1;

    logic [STEP_W-1:0] step;

    always_comb begin
        step = STEP_W'(STEP_NS);
        if (corr_fire)
            step = corr_add ? step + STEP_W'(corr_mag) : step - STEP_W'(corr_mag);
    end

    always_ff @(posedge clk) begin
        if (rst)             time_ns <= '0;
        else if (load_lo_we) time_ns[REG_W-1:0] <= wdata;
        else if (load_hi_we) time_ns[TIME_W-1:REG_W] <= wdata;
        else if (run)        time_ns <= time_ns + TIME_W'(step);
    end

endmodule

// File: rtl/ns_time_counter.sv
module ns_time_counter
    import nsc_pkg::*;
#(
    parameter int STEP_NS    = 16,
    parameter int QUANTUM_NS = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic        rd_en,
    input  logic [2:0]  addr,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    output logic [63:0] time_ns
);

    logic             paused;
    logic             drift_hold;
    drift_cfg_t       cfg;
    logic             load_lo_we;
    logic             load_hi_we;
    logic [REG_W-1:0] snap_hi;
    logic             corr_fire;
    logic             corr_add;
    logic [MAG_W-1:0] corr_mag;

    nsc_regif u_regif (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .rd_en      (rd_en),
        .addr       (addr),
        .wdata      (wdata),
        .time_ns    (time_ns),
        .paused     (paused),
        .drift_hold (drift_hold),
        .cfg        (cfg),
        .load_lo_we (load_lo_we),
        .load_hi_we (load_hi_we),
        .snap_hi    (snap_hi),
        .rdata      (rdata)
    );

    nsc_drift #(.STEP_NS(STEP_NS), .QUANTUM_NS(QUANTUM_NS)) u_drift (
        .clk       (clk),
        .rst       (rst),
        .run       (!paused),
        .hold      (drift_hold),
        .cfg       (cfg),
        .corr_fire (corr_fire),
        .corr_add  (corr_add),
        .corr_mag  (corr_mag)
    );

    nsc_count #(.STEP_NS(STEP_NS)) u_count (
        .clk        (clk),
        .rst        (rst),
        .run        (!paused),
        .load_lo_we (load_lo_we),
        .load_hi_we (load_hi_we),
        .wdata      (wdata),
        .corr_fire  (corr_fire),
        .corr_add   (corr_add),
        .corr_mag   (corr_mag),
        .time_ns    (time_ns)
    );

endmodule

// File: rtl/nsc_checker.sv
module nsc_checker #(
    parameter int STEP_NS = 16
) (
    input logic        clk,
    input logic        rst,
    input logic        paused,
    input logic        drift_hold,
    input logic [31:0] cfg_word,
    input logic        load_lo_we,
    input logic        load_hi_we,
    input logic        corr_fire,
    input logic        corr_add,
    input logic [2:0]  corr_mag,
    input logic        rd_en,
    input logic [2:0]  addr,
    input logic [31:0] snap_hi,
    input logic [63:0] time_ns
);

    a_r2_nominal_step: assert property (@(posedge clk) disable iff (rst)
        (!paused && !corr_fire) |=> time_ns == $past(time_ns) + 64'(STEP_NS));

    a_r3_frozen: assert property (@(posedge clk) disable iff (rst)
        (paused && !load_lo_we && !load_hi_we) |=> time_ns == $past(time_ns));

    a_r5_cfg_locked: assert property (@(posedge clk) disable iff (rst)
        !drift_hold |=> $stable(cfg_word));

    a_r7_add_step: assert property (@(posedge clk) disable iff (rst)
        (corr_fire && corr_add) |=>
            time_ns == $past(time_ns) + 64'(STEP_NS) + 64'($past(corr_mag)));

    a_r7_sub_step: assert property (@(posedge clk) disable iff (rst)
        (corr_fire && !corr_add) |=>
            time_ns == $past(time_ns) + 64'(STEP_NS) - 64'($past(corr_mag)));

    a_r8_zero_mag_quiet: assert property (@(posedge clk) disable iff (rst)
        (corr_mag == 3'd0) |-> !corr_fire);

    a_r9_hold_no_fire: assert property (@(posedge clk) disable iff (rst)
        (drift_hold || paused) |-> !corr_fire);

    a_r10_capture_hi: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == 3'd5) |=> snap_hi == $past(time_ns[63:32]));

endmodule

bind ns_time_counter nsc_checker #(.STEP_NS(STEP_NS)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .paused     (paused),
    .drift_hold (drift_hold),
    .cfg_word   (cfg),
    .load_lo_we (load_lo_we),
    .load_hi_we (load_hi_we),
    .corr_fire  (corr_fire),
    .corr_add   (corr_add),
    .corr_mag   (corr_mag),
    .rd_en      (rd_en),
    .addr       (addr),
    .snap_hi    (snap_hi),
    .time_ns    (time_ns)
);

// File: tb/ns_time_counter_tb.sv
module ns_time_counter_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [63:0] time_ns;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    ns_time_counter u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .time_ns(time_ns)
    );

    typedef struct packed {
        logic [63:0] start;
        logic [15:0] idle;
        logic [31:0] cfg;
        logic [63:0] expv;
    } vec_t;

    // running increments per vector = idle + 1
    localparam vec_t [0:7] VECS = '{
        '{64'd0,                  16'd9,  32'h0000_0000, 64'd160},
        '{64'h0000_0000_FFFF_FF00, 16'd15, 32'h0000_0000, 64'h0000_0001_0000_0000},
        '{64'd1000,               16'd19, 32'hB000_0005, 64'd1332},
        '{64'd1000,               16'd19, 32'h7000_0004, 64'd1285},
        '{64'd0,                  16'd7,  32'hA000_0001, 64'd144},
        '{64'd100,                16'd3,  32'h1000_0000, 64'd160},
        '{64'd0,                  16'd9,  32'h8000_0002, 64'd160},
        '{64'hFFFF_FFFF_FFFF_FFF0, 16'd0,  32'h0000_0000, 64'd0}
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, expv);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic rd64(output logic [63:0] v);
        logic [31:0] lo, hi;
        rd(3'd5, lo);
        rd(3'd6, hi);
        v = {hi, lo};
    endtask

    task automatic set_drift(input logic [31:0] c);
        wr(3'd4, 32'd1);
        wr(3'd3, c);
        wr(3'd4, 32'd0);
    endtask

    task automatic load(input logic [63:0] v);
        wr(3'd1, v[31:0]);
        wr(3'd2, v[63:32]);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] r;
        logic [63:0] t1, t2, v;

        repeat (3) @(negedge clk);
        chk("R1 time in reset", time_ns, 64'd0);
        rst = 1'b0;
        @(negedge clk);
        t1 = time_ns;
        @(negedge clk);
        t2 = time_ns;
        chk("R2 nominal step", t2 - t1, 64'd16);
        rd(3'd0, r); chk("R1 status running", {32'd0, r}, 64'd0);
        rd(3'd3, r); chk("R1 drift word", {32'd0, r}, 64'd0);
        rd(3'd4, r); chk("R1 hold bit", {32'd0, r}, 64'd0);

        // table walk: pause, program, load, run idle+1 cycles, pause, read
        for (int i = 0; i < 8; i++) begin
            wr(3'd0, 32'd2);
            set_drift(VECS[i].cfg);
            load(VECS[i].start);
            wr(3'd0, 32'd4);
            repeat (int'(VECS[i].idle)) @(negedge clk);
            wr(3'd0, 32'd2);
            rd64(v);
            chk($sformatf("R2/R7/R8 vector %0d", i), v, VECS[i].expv);
        end

        // R3: paused status, stray command values, frozen time
        rd(3'd0, r); chk("R3 status paused", {32'd0, r}, 64'd1);
        rd64(t1);
        wr(3'd0, 32'd1);
        wr(3'd0, 32'd7);
        repeat (3) @(negedge clk);
        rd64(t2);
        chk("R3 frozen under other commands", t2, t1);
        rd(3'd0, r); chk("R3 still paused", {32'd0, r}, 64'd1);

        // R6: hold readback
        wr(3'd4, 32'd1);
        rd(3'd4, r); chk("R6 hold set", {32'd0, r}, 64'd1);
        wr(3'd3, 32'hD000_0003);
        wr(3'd4, 32'd0);
        rd(3'd4, r); chk("R6 hold clear", {32'd0, r}, 64'd0);

        // R5: write with hold clear is ignored
        wr(3'd3, 32'h0000_1234);
        rd(3'd3, r); chk("R5 drift word kept", {32'd0, r}, 64'h0000_0000_D000_0003);

        // R9: period 3, +5; two running cycles leave countdown mid-interval
        load(64'd0);
        wr(3'd0, 32'd4);
        @(negedge clk);
        wr(3'd0, 32'd2);
        rd64(v); chk("R9 partial interval", v, 64'd32);
        wr(3'd4, 32'd1);
        wr(3'd4, 32'd0);
        wr(3'd0, 32'd4);
        @(negedge clk);
        wr(3'd0, 32'd2);
        rd64(v); chk("R9 fresh interval after hold", v, 64'd64);

        // R4: load while running ignored; 6 running edges
        set_drift(32'd0);
        load(64'h100);
        wr(3'd0, 32'd4);
        repeat (4) @(negedge clk);
        wr(3'd1, 32'hDEAD);
        wr(3'd0, 32'd2);
        rd64(v); chk("R4 running load ignored", v, 64'h160);

        // R10: captured high half survives a later load
        load(64'h0000_0005_0000_0000);
        rd(3'd5, r);
        wr(3'd2, 32'd9);
        rd(3'd6, r); chk("R10 captured high", {32'd0, r}, 64'd5);
        rd64(v); chk("R10 fresh pair", v, 64'h0000_0009_0000_0000);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule